// File: doc/BRIEF.md
# Fixed-Point to Sign-Magnitude Float Encoder

This block turns a 16-bit sign-magnitude fixed-point word into a 16-bit floating-point word. The input has a sign bit on top, and below it a 15-bit magnitude scaled by 2^-5, so the value has ten integer bits and five fraction bits. The output holds a fractional mantissa kept between one half and one, with no hidden bit. The mantissa and the exponent each carry their own sign bit.

A word is offered with `in_valid`. One clock later the encoded word appears on `out_data` with `out_valid` high. The block takes a word on every cycle and has no back-pressure, so it has no ready signal: a producer may stream one word per clock, and the consumer must accept each result in the cycle it is flagged.

Internally the block finds the leading one of the magnitude and shifts it to the top of the mantissa. It rounds the mantissa to nine bits using the first bit that is dropped. If rounding carries out of the mantissa, it renormalises the mantissa and corrects the exponent.

Top module: `fxf_encoder`

## Requirements
- R1: The output word holds four fields, from MSB down: bit 15 is the mantissa sign, bits 14..6 are the 9-bit mantissa (bit 14 has weight 1/2), bit 5 is the exponent sign, and bits 4..0 are the exponent magnitude. The represented value is M × 2^E. An input of 7.0 gives 0_111000000_0_00011.
- R2: For every nonzero input magnitude, output bit 14 (the first mantissa bit after the point) is 1.
- R3: The exponent E equals p − 4, where p is the position of the leading one in the 15-bit magnitude and bit 0 is position 0. E is written in sign-magnitude form with sign 1 for negative. An input of 0.25 gives 0_100000000_1_00001.
- R4: For a nonzero magnitude, the output mantissa sign equals input bit 15 (0 positive, 1 negative).
- R5: The mantissa is cut to 9 bits. One is added at the last kept bit when the first discarded bit is 1. Nothing is added when that bit is 0.
- R6: When rounding carries out of the mantissa, the mantissa becomes 100000000 and E is raised by one, with the exponent sign and magnitude re-encoded.
- R7: A zero magnitude gives an all-zero output word, whatever the input sign bit is.
- R8: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `out_data` changes only in the cycle after an accepted word and holds its value otherwise.
- R9: A synchronous active-high reset clears `out_valid` and `out_data` to zero at the next clock edge.
- R10: An exponent field of sign 1 with magnitude 0 is never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word present this cycle |
| in_data | input | 16 | Sign bit plus 15-bit magnitude scaled by 2^-5 |
| out_valid | output | 1 | Encoded word present this cycle |
| out_data | output | 16 | Mantissa sign, mantissa, exponent sign, exponent magnitude |

## Verification
The bench sweeps every one of the 65,536 input words, both signs and all magnitudes. It computes the expected mantissa by integer division with half-up rounding, not by shifting.

The sweep covers words with all-ones upper bits and a set round bit. A design that misses renormalisation would wrap the mantissa to zero there, or leave the exponent one too small. Tiny fractions such as 2^-5 need exponent −4. A design that handles the sign poorly would emit a negative-zero exponent or a wrong magnitude. Negative zero must encode as all zeros, so a design that copies the sign bit blindly would emit 0x8000.

Separate checks cover the one-cycle strobe, holding the output while `in_valid` is low, and a reset that arrives while the stream is running.

// File: rtl/fxf_pkg.sv
package fxf_pkg;
  localparam int IN_W   = 16;
  localparam int FRAC_W = 5;
  localparam int MANT_W = 9;
  localparam int EXP_W  = 5;

  localparam int MAG_W  = IN_W - 1;
  localparam int POS_W  = $clog2(MAG_W);
  localparam int OUT_W  = 1 + MANT_W + 1 + EXP_W;

  typedef struct packed {
    logic              m_sign;
    logic [MANT_W-1:0] mant;
    logic              e_sign;
    logic [EXP_W-1:0]  e_mag;
  } fxf_word_t;
endpackage

// File: rtl/fxf_lead_one.sv
module fxf_lead_one #(
  parameter int W     = 15,
  parameter int POS_W = $clog2(W)
) (
  input  logic [W-1:0]     vec,
  output logic [POS_W-1:0] pos,
  output logic             any
);
  always_comb begin
    pos = '0;
    any = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) begin
        pos = POS_W'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fxf_norm_round.sv
module fxf_norm_round #(
  parameter int MAG_W  = 15,
  parameter int MANT_W = 9,
  parameter int POS_W  = $clog2(MAG_W)
) (
  input  logic [MAG_W-1:0]  mag,
  input  logic [POS_W-1:0]  lead,
  output logic [MANT_W-1:0] mant,
  output logic              carry
);
  localparam int PAD = (MAG_W > MANT_W) ? 0 : (MANT_W + 1 - MAG_W);
  localparam int NW  = MAG_W + PAD;

  logic [POS_W-1:0]  shamt;
  logic [NW-1:0]     nrm;
  logic [MANT_W-1:0] kept;
  logic              rbit;
  logic [MANT_W:0]   sum;

  assign shamt = POS_W'(MAG_W - 1) - lead;

  generate
    if (PAD == 0) begin : g_nopad
      assign nrm = mag << shamt;
    end else begin : g_pad
      assign nrm = {mag, {PAD{1'b0}}} << shamt;
    end
  endgenerate

  assign kept  = nrm[NW-1 -: MANT_W];
  assign rbit  = nrm[NW-1-MANT_W];
  assign sum   = {1'b0, kept} + {{MANT_W{1'b0}}, rbit};
  assign carry = sum[MANT_W];
  assign mant  = carry ? {1'b1, {(MANT_W-1){1'b0}}} : sum[MANT_W-1:0];
endmodule

// File: rtl/fxf_exp_enc.sv
module fxf_exp_enc #(
  parameter int POS_W  = 4,
  parameter int FRAC_W = 5,
  parameter int EXP_W  = 5
) (
  input  logic [POS_W-1:0] lead,
  input  logic             carry,
  output logic             e_sign,
  output logic [EXP_W-1:0] e_mag
);
  localparam int SW   = ((POS_W > EXP_W) ? POS_W : EXP_W) + 2;
  localparam int BIAS = FRAC_W - 1;

  logic signed [SW-1:0] e_full;
  logic signed [SW-1:0] e_abs;

  assign e_full = $signed({{(SW-POS_W){1'b0}}, lead})
                - $signed(SW'(BIAS))
                + $signed({{(SW-1){1'b0}}, carry});
  assign e_sign = e_full[SW-1];
  assign e_abs  = e_sign ? -e_full : e_full;
  assign e_mag  = e_abs[EXP_W-1:0];
endmodule

// File: rtl/fxf_encoder.sv
module fxf_encoder
  import fxf_pkg::*;
#(
  parameter int P_IN_W   = IN_W,
  parameter int P_FRAC_W = FRAC_W,
  parameter int P_MANT_W = MANT_W,
  parameter int P_EXP_W  = EXP_W
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 in_valid,
  input  logic [P_IN_W-1:0]                    in_data,
  output logic                                 out_valid,
  output logic [P_MANT_W+P_EXP_W+1:0]          out_data
);
  localparam int L_MAG_W = P_IN_W - 1;
  localparam int L_POS_W = $clog2(L_MAG_W);
  localparam int L_OUT_W = P_MANT_W + P_EXP_W + 2;

  logic [L_MAG_W-1:0]  mag;
  logic [L_POS_W-1:0]  lead;
  logic                nonzero;
  logic [P_MANT_W-1:0] mant;
  logic                carry;
  logic                e_sign;
  logic [P_EXP_W-1:0]  e_mag;
  logic [L_OUT_W-1:0]  word_nxt;

  assign mag = in_data[L_MAG_W-1:0];

  fxf_lead_one #(.W(L_MAG_W), .POS_W(L_POS_W)) u_lead (
    .vec (mag),
    .pos (lead),
    .any (nonzero)
  );

  fxf_norm_round #(.MAG_W(L_MAG_W), .MANT_W(P_MANT_W), .POS_W(L_POS_W)) u_round (
    .mag   (mag),
    .lead  (lead),
    .mant  (mant),
    .carry (carry)
  );

  fxf_exp_enc #(.POS_W(L_POS_W), .FRAC_W(P_FRAC_W), .EXP_W(P_EXP_W)) u_exp (
    .lead   (lead),
    .carry  (carry),
    .e_sign (e_sign),
    .e_mag  (e_mag)
  );

  always_comb begin
    if (nonzero) word_nxt = {in_data[P_IN_W-1], mant, e_sign, e_mag};
    else         word_nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= word_nxt;
    end
  end
endmodule

// File: rtl/fxf_encoder_chk.sv
module fxf_encoder_chk #(
  parameter int IW = 16,
  parameter int OW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [IW-1:0] in_data,
  input logic          out_valid,
  input logic [OW-1:0] out_data
);
  assert_reset_R9: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0));

  assert_valid_R8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_novalid_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data));

  assert_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_data[IW-2:0] == '0) |=> out_data == '0);

  assert_sign_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_data[IW-2:0] != '0) |=> out_data[OW-1] == $past(in_data[IW-1]));

  assert_norm_R2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_data != '0) |-> out_data[OW-2]);

  assert_posexp_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_data[IW-2:5] != '0) |=> !out_data[5]);

  assert_no_negzero_R10: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_data[5:0] != 6'b100000);
endmodule

bind fxf_encoder fxf_encoder_chk #(.IW(16), .OW(16)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/fxf_encoder_tb.sv
module fxf_encoder_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic [15:0] out_data;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  fxf_encoder u_dut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  function automatic logic [15:0] model(input logic [15:0] w, output string tag);
    int mag, p, t, mnt, e, em;
    mag = int'(w[14:0]);
    tag = "R3";
    if (mag == 0) begin
      tag = "R7";
      return 16'h0000;
    end
    p = 0;
    for (int i = 0; i < 15; i++) if (w[i]) p = i;
    t   = (mag * 1024) / (1 << (p + 1));
    mnt = (t + 1) / 2;
    e   = p - 4;
    if (t % 2 == 1) tag = "R5";
    if (mnt == 512) begin
      mnt = 256;
      e   = e + 1;
      tag = "R6";
    end
    em = (e < 0) ? -e : e;
    return {w[15], 9'(mnt), (e < 0), 5'(em)};
  endfunction

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    string tg;
    logic [15:0] prev;
    logic [15:0] ex;
    repeat (3) @(negedge clk);
    check("R9", {15'd0, out_valid}, 16'd0);
    check("R9", out_data, 16'd0);
    rst = 1'b0;

    // R1: 7.0 -> 0_111000000_0_00011
    in_valid = 1'b1; in_data = 16'd224;
    @(negedge clk);
    check("R1", out_data, 16'b0_111000000_0_00011);
    check("R8", {15'd0, out_valid}, 16'd1);
    // R3: 0.25 -> 0_100000000_1_00001
    in_data = 16'd8;
    @(negedge clk);
    check("R3", out_data, 16'b0_100000000_1_00001);
    // R8: hold when in_valid low, other data on bus
    in_valid = 1'b0; in_data = 16'h7fff;
    @(negedge clk);
    check("R8", {15'd0, out_valid}, 16'd0);
    check("R8", out_data, 16'b0_100000000_1_00001);
    // R4: negative 7
    in_valid = 1'b1; in_data = 16'h8000 | 16'd224;
    @(negedge clk);
    check("R4", out_data, 16'b1_111000000_0_00011);
    // R7: negative zero
    in_data = 16'h8000;
    @(negedge clk);
    check("R7", out_data, 16'd0);
    // R6: all ones rounds up to exponent 11
    in_data = 16'h7fff;
    @(negedge clk);
    check("R6", out_data, 16'b0_100000000_0_01011);
    // R9: reset during stream
    rst = 1'b1; in_data = 16'd224;
    @(negedge clk);
    check("R9", {15'd0, out_valid}, 16'd0);
    check("R9", out_data, 16'd0);
    rst = 1'b0;

    // exhaustive sweep, one word per clock
    prev = '0;
    for (int v = 0; v <= 65536; v++) begin
      if (v > 0) begin
        ex = model(prev, tg);
        check(tg, out_data, ex);
        if (prev[14:0] != 0) check("R2", {15'd0, out_data[14]}, 16'd1);
        check("R10", {15'd0, (out_data[5:0] == 6'b100000)}, 16'd0);
      end
      if (v < 65536) begin
        in_data = 16'(v);
        prev    = 16'(v);
        @(negedge clk);
      end
    end
    in_valid = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule